// File: doc/BRIEF.md
# CAN Controller Mode Word and Interrupt Request Logic

This block holds the software-visible mode word of a CAN controller and produces the controller's single interrupt request. A CPU reads and writes the mode word over a simple word-addressed register bus. The word holds the initialisation flag, three interrupt enables, the retransmission-disable flag, the configuration-change flag and the test-mode flag. Each of these flags is also driven out as a pin for the protocol engine. The block also tells the bit-timing register when it may accept a write.

The live status bits come from the protocol engine. They are transmit-OK, receive-OK, a 3-bit last-error code, bus-off and error-warning. The block compares each one with its value in the previous cycle. A change in any of them sets one of two sticky pending flags: one for the status group and one for the error group. Software reads the pending flags at a second address and clears them there by writing ones. The interrupt line is driven only while the global enable is set and an enabled group has its pending flag set. When the engine goes bus-off, it can force the initialisation flag on through a dedicated input.

Top module: `can_mode_ctrl`

## Requirements
- R1: Address 0 reads the mode word as {24'b0, test[7], cfg_change[6], no_retx[5], 0[4], err_ie[3], sts_ie[2], glob_ie[1], init[0]}. A write to address 0 loads those seven flags from the matching write-data bits in the next cycle, and each flag is driven on its own output pin.
- R2: Bit 4 and bits 31..8 of address 0 always read 0, whatever value was written.
- R3: After a synchronous active-low reset, address 0 reads 0x00000001, address 1 reads 0, the interrupt line is low and the timing-write permit is low.
- R4: `timing_wr_ok` is 1 exactly when both the init flag and the cfg_change flag are 1.
- R5: A change in either direction of bus-off or error-warning, compared with the previous cycle, sets the error pending flag. With err_ie and glob_ie both set, the interrupt line then goes high in the cycle after the change.
- R6: A change in either direction of transmit-OK, receive-OK or any bit of the last-error code sets the status pending flag. With sts_ie and glob_ie both set, the interrupt line then goes high in the cycle after the change.
- R7: While glob_ie is 0, the interrupt line is 0 whatever the pending flags and group enables are.
- R8: Address 1 reads {30'b0, err_pending[1], sts_pending[0]}. Both flags hold until a write to address 1 with a 1 in the matching bit clears them. If a change occurs in the same cycle as the clear, the flag stays set.
- R9: When `hw_init_set` is 1, the init flag is 1 in the next cycle, even if a CPU write of 0 to address 0 happens in the same cycle.
- R10: Pending flags latch whether or not their group enable is set. Setting the enable later raises the interrupt line without a new change.
- R11: Addresses other than 0 and 1 read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sts_txok | input | 1 | Live transmit-OK status |
| sts_rxok | input | 1 | Live receive-OK status |
| sts_lec | input | LEC_W | Live last-error code |
| sts_boff | input | 1 | Live bus-off status |
| sts_ewarn | input | 1 | Live error-warning status |
| hw_init_set | input | 1 | Engine request to force init on |
| ctl_init | output | 1 | Initialisation flag |
| ctl_glob_ie | output | 1 | Global interrupt enable |
| ctl_sts_ie | output | 1 | Status-group interrupt enable |
| ctl_err_ie | output | 1 | Error-group interrupt enable |
| ctl_no_retx | output | 1 | Automatic retransmission disabled |
| ctl_cfg_change | output | 1 | Configuration change enable |
| ctl_test | output | 1 | Test mode enable |
| timing_wr_ok | output | 1 | Bit-timing register write permit |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a status change that lands in the same cycle as a software clear of the same group. A second hard case is a change that latches while its enable is off and only raises the line once software turns the enable on. Random stimulus rarely lines these up, so directed steps build each case: a clear write to address 1 is issued in the same cycle the last-error code flips, and a change is followed by a later enable write. A long seeded random phase then mixes writes, rare single-bit status flips and engine init requests. A bench model predicts every read and pin in each cycle.

// File: rtl/ccr_pkg.sv
// Package: shared field positions, masks and the mode word type.
// Assumes the mode word occupies the low CTL_W bits of a WORD_W bus word.
package ccr_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned CTL_W  = 8;

    // Bit positions inside the mode word (software decodes these)
    localparam int unsigned B_INIT    = 0;
    localparam int unsigned B_GLOB_IE = 1;
    localparam int unsigned B_STS_IE  = 2;
    localparam int unsigned B_ERR_IE  = 3;
    localparam int unsigned B_RSV     = 4;
    localparam int unsigned B_NO_RETX = 5;
    localparam int unsigned B_CFG     = 6;
    localparam int unsigned B_TEST    = 7;

    // Writable bits and reset value of the mode word
    localparam logic [CTL_W-1:0] CTL_WR_MASK = 8'hEF;
    localparam logic [CTL_W-1:0] CTL_RESET   = 8'h01;

    // Bit positions in the pending word
    localparam int unsigned P_STS = 0;
    localparam int unsigned P_ERR = 1;

    // Mode word, most significant field first
    typedef struct packed {
        logic test;
        logic cfg;
        logic no_retx;
        logic rsv;
        logic err_ie;
        logic sts_ie;
        logic glob_ie;
        logic init;
    } ctl_t;
endpackage

// File: rtl/ccr_ctl_word.sv
// Module: holds the mode word.
// A CPU write loads the writable bits; the reserved bit stays 0.
// An engine init request forces init on and beats a CPU write in the same cycle.
// Assumes wr_en is already qualified by address decode.
module ccr_ctl_word
    import ccr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wdata,
    input  logic             hw_init_set,
    output ctl_t             ctl_q
);
    logic [CTL_W-1:0] word_q;
    logic [CTL_W-1:0] word_d;

    // Next value: CPU write masked, then engine init request on top
    always_comb begin
        word_d = word_q;
        if (wr_en) begin
            word_d = wdata & CTL_WR_MASK;
        end
        if (hw_init_set) begin
            word_d[B_INIT] = 1'b1;
        end
    end

    // Mode word register with synchronous reset to the reset value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= CTL_RESET;
        end else begin
            word_q <= word_d;
        end
    end

    assign ctl_q = ctl_t'(word_q);

    // R9: an engine request always leaves init set
    p_hw_init_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hw_init_set |=> ctl_q.init);

    // R2: the reserved bit never becomes 1
    p_rsv_stays_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !ctl_q.rsv);

    // R1: with no write and no request, the word holds
    p_word_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !hw_init_set) |=> $stable(ctl_q));
endmodule

// File: rtl/ccr_chg_latch.sv
// Module: change detector with a sticky pending flag for a group of W status bits.
// The previous-cycle copy is loaded from the live inputs during reset, so release
// from reset never looks like a change. A change beats a clear in the same cycle.
// Assumes sts_in is synchronous to clk.
module ccr_chg_latch #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sts_in,
    input  logic         clr,
    output logic         pend
);
    logic [W-1:0] prev_q;
    logic         chg;

    // Any bit differing from last cycle counts as a change
    assign chg = |(sts_in ^ prev_q);

    // Previous-cycle copy and the sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= sts_in;
            pend   <= 1'b0;
        end else begin
            prev_q <= sts_in;
            if (chg) begin
                pend <= 1'b1;
            end else if (clr) begin
                pend <= 1'b0;
            end
        end
    end

    // R10: a change latches the flag regardless of any enable
    p_edge_sets_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_in != prev_q) |=> pend);

    // R8: without a clear the flag is sticky
    p_pend_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend);

    // R8: the flag only rises after a change
    p_pend_needs_chg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(sts_in != prev_q));
endmodule

// File: rtl/ccr_irq_gate.sv
// Module: interrupt line and bit-timing write permit.
// Each pending flag counts only while its group enable is set, and the global
// enable gates the result. Purely combinational; clk and rst_n serve the checks.
module ccr_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic cfg,
    input  logic glob_ie,
    input  logic sts_ie,
    input  logic err_ie,
    input  logic pend_sts,
    input  logic pend_err,
    output logic irq,
    output logic timing_wr_ok
);
    logic grp_req;

    // Collect the enabled group requests
    always_comb begin
        grp_req = (sts_ie & pend_sts) | (err_ie & pend_err);
    end

    assign irq          = glob_ie & grp_req;
    assign timing_wr_ok = init & cfg;

    // R7: the global enable off silences the line
    p_gie_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_ie |-> !irq);

    // R4: no permit while init is clear
    p_timing_needs_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !init |-> !timing_wr_ok);

    // R5: the line never rises without a pending flag behind it
    p_irq_has_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend_sts || pend_err));
endmodule

// File: rtl/can_mode_ctrl.sv
// Module: top. Decodes the register bus, instantiates the mode word, the two
// change latches and the interrupt gate, and muxes read data.
// Address 0 is the mode word, address 1 the pending word (write one to clear).
// Assumes single-cycle writes and combinational reads.
module can_mode_ctrl
    import ccr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned LEC_W    = 3,
    parameter int unsigned CTL_ADDR = 0,
    parameter int unsigned PND_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              sts_txok,
    input  logic              sts_rxok,
    input  logic [LEC_W-1:0]  sts_lec,
    input  logic              sts_boff,
    input  logic              sts_ewarn,
    input  logic              hw_init_set,
    output logic              ctl_init,
    output logic              ctl_glob_ie,
    output logic              ctl_sts_ie,
    output logic              ctl_err_ie,
    output logic              ctl_no_retx,
    output logic              ctl_cfg_change,
    output logic              ctl_test,
    output logic              timing_wr_ok,
    output logic              irq
);
    localparam int unsigned STS_W = LEC_W + 2;
    localparam int unsigned ERR_W = 2;
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_ADDR);
    localparam logic [ADDR_W-1:0] A_PND = ADDR_W'(PND_ADDR);

    ctl_t       ctl_q;
    logic       sel_ctl;
    logic       sel_pnd;
    logic       wr_ctl;
    logic       clr_sts;
    logic       clr_err;
    logic       pend_sts;
    logic       pend_err;
    logic [STS_W-1:0] sts_grp;
    logic [ERR_W-1:0] err_grp;
    logic       unused_wdata;

    // Address decode and write strobes
    always_comb begin
        sel_ctl = (bus_addr == A_CTL);
        sel_pnd = (bus_addr == A_PND);
        wr_ctl  = bus_wr & sel_ctl;
        clr_sts = bus_wr & sel_pnd & bus_wdata[P_STS];
        clr_err = bus_wr & sel_pnd & bus_wdata[P_ERR];
    end

    assign unused_wdata = ^bus_wdata[WORD_W-1:CTL_W];
    assign sts_grp = {sts_txok, sts_rxok, sts_lec};
    assign err_grp = {sts_boff, sts_ewarn};

    ccr_ctl_word i_word (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_ctl),
        .wdata       (bus_wdata[CTL_W-1:0]),
        .hw_init_set (hw_init_set),
        .ctl_q       (ctl_q)
    );

    ccr_chg_latch #(.W(STS_W)) i_sts_chg (
        .clk    (clk),
        .rst_n  (rst_n),
        .sts_in (sts_grp),
        .clr    (clr_sts),
        .pend   (pend_sts)
    );

    ccr_chg_latch #(.W(ERR_W)) i_err_chg (
        .clk    (clk),
        .rst_n  (rst_n),
        .sts_in (err_grp),
        .clr    (clr_err),
        .pend   (pend_err)
    );

    ccr_irq_gate i_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .init         (ctl_q.init),
        .cfg          (ctl_q.cfg),
        .glob_ie      (ctl_q.glob_ie),
        .sts_ie       (ctl_q.sts_ie),
        .err_ie       (ctl_q.err_ie),
        .pend_sts     (pend_sts),
        .pend_err     (pend_err),
        .irq          (irq),
        .timing_wr_ok (timing_wr_ok)
    );

    // Read data mux: mode word, pending word, zero elsewhere
    always_comb begin
        bus_rdata = '0;
        if (sel_ctl) begin
            bus_rdata[CTL_W-1:0] = ctl_q;
        end else if (sel_pnd) begin
            bus_rdata[P_STS] = pend_sts;
            bus_rdata[P_ERR] = pend_err;
        end
    end

    assign ctl_init       = ctl_q.init;
    assign ctl_glob_ie    = ctl_q.glob_ie;
    assign ctl_sts_ie     = ctl_q.sts_ie;
    assign ctl_err_ie     = ctl_q.err_ie;
    assign ctl_no_retx    = ctl_q.no_retx;
    assign ctl_cfg_change = ctl_q.cfg;
    assign ctl_test       = ctl_q.test;

    // R2: reserved bits of the mode word read zero
    p_rsv_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ctl |-> (bus_rdata[B_RSV] == 1'b0 && bus_rdata[WORD_W-1:CTL_W] == '0));

    // R11: unmapped addresses read zero
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ctl && !sel_pnd) |-> (bus_rdata == '0));

    // R6: an enabled status change with global enable raises the line next cycle
    p_sts_raises_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_grp != $past(sts_grp)) && ctl_q.glob_ie && ctl_q.sts_ie
         && !wr_ctl && !hw_init_set) |=> irq);
endmodule

// File: tb/test_can_mode_ctrl.sv
// Bench: directed corner cases then seeded random traffic, checked each cycle
// against a bench model of the mode word, pending flags and outputs.
module test_can_mode_ctrl;
    localparam int unsigned AW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sts_txok = 1'b0, sts_rxok = 1'b0, sts_boff = 1'b0, sts_ewarn = 1'b0;
    logic [2:0]  sts_lec = '0;
    logic        hw_init_set = 1'b0;
    logic ctl_init, ctl_glob_ie, ctl_sts_ie, ctl_err_ie, ctl_no_retx, ctl_cfg_change, ctl_test;
    logic timing_wr_ok, irq;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;
    bit done = 1'b0;

    // bench model state
    logic [7:0] m_ctl = 8'h01;
    logic       m_ps = 1'b0, m_pe = 1'b0;
    logic [4:0] m_prev_s = '0;
    logic [1:0] m_prev_e = '0;

    always #4 clk = ~clk;

    can_mode_ctrl i_can_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sts_txok(sts_txok),
        .sts_rxok(sts_rxok), .sts_lec(sts_lec), .sts_boff(sts_boff),
        .sts_ewarn(sts_ewarn), .hw_init_set(hw_init_set), .ctl_init(ctl_init),
        .ctl_glob_ie(ctl_glob_ie), .ctl_sts_ie(ctl_sts_ie), .ctl_err_ie(ctl_err_ie),
        .ctl_no_retx(ctl_no_retx), .ctl_cfg_change(ctl_cfg_change), .ctl_test(ctl_test),
        .timing_wr_ok(timing_wr_ok), .irq(irq)
    );

    function automatic logic [31:0] exp_rd(input logic [AW-1:0] a);
        if (a == 0) return {24'h0, m_ctl};
        if (a == 1) return {30'h0, m_pe, m_ps};
        return 32'h0;
    endfunction

    function automatic logic exp_irq();
        return m_ctl[1] & ((m_ctl[2] & m_ps) | (m_ctl[3] & m_pe));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // model update for one clock edge using the current inputs
    task automatic model_edge();
        logic [4:0] s_now;
        logic [1:0] e_now;
        s_now = {sts_txok, sts_rxok, sts_lec};
        e_now = {sts_boff, sts_ewarn};
        if (bus_wr && bus_addr == 1 && bus_wdata[0]) m_ps = 1'b0;
        if (bus_wr && bus_addr == 1 && bus_wdata[1]) m_pe = 1'b0;
        if (s_now != m_prev_s) m_ps = 1'b1;
        if (e_now != m_prev_e) m_pe = 1'b1;
        if (bus_wr && bus_addr == 0) m_ctl = bus_wdata[7:0] & 8'hEF;
        if (hw_init_set) m_ctl[0] = 1'b1;
        m_prev_s = s_now;
        m_prev_e = e_now;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R1/R2/R8/R11 read"}, bus_rdata, exp_rd(bus_addr));
        chk({tag, " R1 pins"}, {24'h0, ctl_test, ctl_cfg_change, ctl_no_retx, 1'b0,
            ctl_err_ie, ctl_sts_ie, ctl_glob_ie, ctl_init}, {24'h0, m_ctl});
        chk({tag, " R4 timing permit"}, {31'h0, timing_wr_ok}, {31'h0, m_ctl[6] & m_ctl[0]});
        chk({tag, " R5/R6/R7 irq"}, {31'h0, irq}, {31'h0, exp_irq()});
    endtask

    // one cycle: inputs already driven; edge; model; sample at negedge
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        step(tag);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        bus_addr = a;
        #1;
        chk({tag, " read"}, bus_rdata, exp_rd(a));
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R3: reset state
        rd(0, "R3 reset ctl");
        rd(1, "R3 reset pend");
        check_all("R3 reset");

        wr(0, 32'hFFFF_FFFF, "R1 R2 write all ones");
        rd(0, "R2 reserved zero");
        wr(0, 32'h0000_0041, "R4 cfg and init");
        wr(0, 32'h0000_0040, "R4 cfg without init");
        wr(0, 32'h0000_0001, "R4 init without cfg");
        hw_init_set = 1'b1;
        wr(0, 32'h0000_0000, "R9 engine init beats write");
        hw_init_set = 1'b0;
        wr(0, 32'h0000_000C, "R7 group enables only");
        sts_txok = 1'b1; step("R7 change with global off");
        rd(1, "R10 pending latched");
        wr(0, 32'h0000_000E, "R10 late enable raises irq");
        wr(1, 32'h1, "R8 clear status pending");
        sts_txok = 1'b0; step("R6 falling change");
        sts_lec = 3'd5; wr(1, 32'h1, "R8 change beats clear");
        sts_boff = 1'b1; step("R5 bus-off change");
        wr(1, 32'h2, "R8 clear error pending");
        sts_ewarn = 1'b1; step("R5 warning change");
        wr(1, 32'h3, "R8 clear both");
        wr(5, 32'hFF, "R11 unmapped write");
        rd(5, "R11 unmapped read");
        rd(0, "R11 word unchanged");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            bus_addr = AW'($urandom % 4);
            bus_wr = ($urandom % 4) == 0;
            bus_wdata = $urandom;
            hw_init_set = ($urandom % 16) == 0;
            if (($urandom % 6) == 0) begin
                case ($urandom % 7)
                    0: sts_txok = ~sts_txok;
                    1: sts_rxok = ~sts_rxok;
                    2: sts_lec = sts_lec ^ 3'b001;
                    3: sts_lec = sts_lec ^ 3'b100;
                    4: sts_boff = ~sts_boff;
                    5: sts_ewarn = ~sts_ewarn;
                    default: sts_lec = 3'($urandom);
                endcase
            end
            step("random R1 R5 R6 R7 R8 R9");
        end
        bus_wr = 1'b0;
        hw_init_set = 1'b0;
        done = 1'b1;
        summary();
        $finish;
    end
endmodule